// File: doc/BRIEF.md
# SPI Master Command-Word Frame Engine

This block is an SPI master that takes 32-bit push words, each a command half and a data half, from a four-entry transmit queue. It shifts every frame out on the serial pins with the configured clock polarity, clock phase, bit order and frame length. Received frames go into a four-entry receive queue that the host drains through a pop port.

Every data frame carries its own command. The command picks the chip-select line, says whether that line stays asserted after the frame, asks for the frame counter to restart, and can mark the last frame of a queue. Frames of more than 16 bits use two pushes. A sticky status register reports frame completion, end of queue, receive overflow and transmit underflow. Software clears its bits by writing ones.

Top module: `spi_cmd_master`

## Requirements
- R1: A push is taken on a clock edge where `push_valid` and `push_ready` are both high. `push_ready` is low while four words wait in the transmit queue.
- R2: The frame length N is `{cfg_size_ext, cfg_size} + 1`. When N is 16 or less, a frame takes data bits [N-1:0] of one push. When N is more than 16, a frame takes two pushes. The first push gives data bits [15:0] and the command. The second push gives bits [31:16], and its command half is ignored.
- R3: With `cfg_lsb_first` = 1, data bit 0 goes out first. Otherwise bit N-1 goes out first. Received bits are placed with the same order.
- R4: `sck` rests at `cfg_cpol` between frames. With `cfg_cpha` = 0, data is sampled on the leading edge of each clock pulse and `mosi` changes on the trailing edge. With `cfg_cpha` = 1, `mosi` changes on the leading edge and data is sampled on the trailing edge.
- R5: Command bits [5:0] are a one-hot line mask. A selected line is driven to the inverse of its `cfg_cs_idle` bit for the whole frame. If command bit 15 (continuous) is set, the line stays asserted after the frame. If it is clear, the line returns to its idle level when the frame completes.
- R6: `pop_valid` is high while the receive queue holds a word, and `pop_data` is the oldest word. Bits N and above of a received word read as zero.
- R7: `xfer_count` rises by one for each completed frame. A frame whose command bit 10 is set leaves `xfer_count` at 1.
- R8: Status bit 0 is set when any frame completes. Status bit 1 is set when a frame with command bit 11 completes. A cycle with `stat_clr_valid` high clears every status bit whose `stat_clr_mask` bit is 1. A flag that is being set wins over a clear in the same cycle.
- R9: When a frame completes while the receive queue holds four words, status bit 2 is set and that frame's word is dropped.
- R10: When a frame with the continuous bit set completes while the transmit queue does not hold the push or pushes the next frame needs, status bit 3 is set.
- R11: A pulse on `flush_tx` empties the transmit queue, so no further queued frame is sent. A pulse on `flush_rx` empties the receive queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Push word offered |
| push_word | input | 32 | Command in [31:16], data in [15:0] |
| push_ready | output | 1 | Transmit queue has room |
| pop_ready | input | 1 | Consumer takes the head word |
| pop_valid | output | 1 | Receive queue not empty |
| pop_data | output | 32 | Oldest received frame, zero above N |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_lsb_first | input | 1 | Shift order, 1 = bit 0 first |
| cfg_size | input | 4 | Frame length minus one, low four bits |
| cfg_size_ext | input | 1 | Frame length minus one, bit 4 |
| cfg_cs_idle | input | 6 | Inactive level of each chip-select line |
| flush_tx | input | 1 | Empty the transmit queue |
| flush_rx | input | 1 | Empty the receive queue |
| stat_clr_valid | input | 1 | Apply a write-one-to-clear |
| stat_clr_mask | input | 4 | Status bits to clear |
| status | output | 4 | {tx underflow, rx overflow, end of queue, frame done} |
| xfer_count | output | 16 | Completed-frame counter |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_o | output | 6 | Chip-select lines |

## Verification
The bench ties `miso` to `mosi`. Each received word therefore shows the frame length and the zeroed upper bits. A pin monitor records `mosi` at the sampling edges, which shows whether the bit order and the clock mode are right.

Frames run as 8-bit MSB-first in mode 0, 12-bit LSB-first in mode 3, and 24-bit across two pushes. The 24-bit case tells a two-push frame apart from a frame built from one push, and shows that the second command half is ignored.

Continuous and released chip selects are run with mixed per-line idle levels. Five back-to-back frames fill the receive queue to bring out an overflow. Five back-to-back pushes fill the transmit queue and are then flushed, which separates back-pressure from a flush.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
    localparam int CS_LINES   = 6;
    localparam int WORD_W     = 32;
    localparam int HALF_W     = 16;
    localparam int STAT_W     = 4;
    // command-half bit positions (decoded by the engine)
    localparam int CMD_CONT   = 15;
    localparam int CMD_EOQ    = 11;
    localparam int CMD_CLRCNT = 10;
    // status bit positions
    localparam int STAT_DONE  = 0;
    localparam int STAT_EOQ   = 1;
    localparam int STAT_RXOVF = 2;
    localparam int STAT_TXUNF = 3;

    typedef enum logic [2:0] {
        ST_IDLE, ST_LOAD2, ST_SETUP, ST_SHIFT, ST_HOLD, ST_FINISH
    } eng_state_e;
endpackage

// File: rtl/spi_cmd_fifo.sv
module spi_cmd_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [AW-1:0]               rd;
        logic [AW-1:0]               wr;
        logic [CW-1:0]               cnt;
    } fifo_s;

    fifo_s d, q;
    logic  do_wr, do_rd;

    always_comb begin
        d     = q;
        do_wr = wr_en && (q.cnt != CW'(DEPTH));
        do_rd = rd_en && (q.cnt != '0);
        if (do_wr) begin
            d.mem[q.wr] = wr_data;
            d.wr        = (q.wr == AW'(DEPTH - 1)) ? '0 : q.wr + AW'(1);
        end
        if (do_rd)
            d.rd = (q.rd == AW'(DEPTH - 1)) ? '0 : q.rd + AW'(1);
        d.cnt = q.cnt + CW'(do_wr) - CW'(do_rd);
        if (flush) begin
            d.rd  = '0;
            d.wr  = '0;
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_data = q.mem[q.rd];
    assign count   = q.cnt;
    assign full    = (q.cnt == CW'(DEPTH));
    assign empty   = (q.cnt == '0);

    // R1 / R9: writers never offer a word to a full queue
    assert_no_write_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full);
    // R6: readers never take from an empty queue
    assert_no_read_when_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int CNT_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_cpol,
    input  logic                cfg_cpha,
    input  logic                cfg_lsb_first,
    input  logic [4:0]          cfg_size_m1,
    input  logic [WORD_W-1:0]   tx_head,
    input  logic [CNT_W-1:0]    tx_count,
    output logic                tx_pop,
    input  logic                rx_full,
    output logic                rx_push,
    output logic [WORD_W-1:0]   rx_word,
    input  logic                miso,
    output logic                sck,
    output logic                mosi,
    output logic [CS_LINES-1:0] cs_mask,
    input  logic                stat_clr_valid,
    input  logic [STAT_W-1:0]   stat_clr_mask,
    output logic [STAT_W-1:0]   status,
    output logic [HALF_W-1:0]   tcnt
);
    localparam int HW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    typedef struct packed {
        eng_state_e          st;
        logic [HW-1:0]       tick;
        logic [5:0]          edg;
        logic                sck;
        logic                mosi;
        logic [CS_LINES-1:0] cs;
        logic                cont;
        logic                eoq;
        logic                clr;
        logic [WORD_W-1:0]   txd;
        logic [WORD_W-1:0]   rxd;
        logic [HALF_W-1:0]   tcnt;
        logic [STAT_W-1:0]   status;
    } eng_s;

    eng_s              d, q;
    logic              half_end;
    logic [4:0]        bitn, cur_idx, nxt_idx, first_idx;
    logic [CNT_W-1:0]  need;
    logic [STAT_W-1:0] sets;
    logic              unused_cmd_bits;

    assign unused_cmd_bits = ^{tx_head[30:28], tx_head[25:22]};

    always_comb begin
        d         = q;
        tx_pop    = 1'b0;
        rx_push   = 1'b0;
        sets      = '0;
        half_end  = (q.tick == HW'(HALF_DIV - 1));
        bitn      = q.edg[5:1];
        cur_idx   = cfg_lsb_first ? bitn : cfg_size_m1 - bitn;
        nxt_idx   = cfg_lsb_first ? bitn + 5'd1 : cfg_size_m1 - bitn - 5'd1;
        first_idx = cfg_lsb_first ? 5'd0 : cfg_size_m1;
        need      = cfg_size_m1[4] ? CNT_W'(2) : CNT_W'(1);

        if (q.st inside {ST_SETUP, ST_SHIFT, ST_HOLD})
            d.tick = half_end ? '0 : q.tick + HW'(1);
        else
            d.tick = '0;

        unique case (q.st)
            ST_IDLE: begin
                d.sck = cfg_cpol;
                if (tx_count >= need) begin
                    tx_pop = 1'b1;
                    d.cont = tx_head[HALF_W + CMD_CONT];
                    d.eoq  = tx_head[HALF_W + CMD_EOQ];
                    d.clr  = tx_head[HALF_W + CMD_CLRCNT];
                    d.cs   = tx_head[HALF_W +: CS_LINES];
                    d.txd  = {{HALF_W{1'b0}}, tx_head[HALF_W-1:0]};
                    d.rxd  = '0;
                    d.edg  = '0;
                    d.st   = cfg_size_m1[4] ? ST_LOAD2 : ST_SETUP;
                end
            end
            ST_LOAD2: begin
                tx_pop                = 1'b1;
                d.txd[WORD_W-1:HALF_W] = tx_head[HALF_W-1:0];
                d.st                  = ST_SETUP;
            end
            ST_SETUP: begin
                if (!cfg_cpha) d.mosi = q.txd[first_idx];
                if (half_end)  d.st   = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (half_end) begin
                    d.sck = ~q.sck;
                    d.edg = q.edg + 6'd1;
                    if (!q.edg[0]) begin
                        if (cfg_cpha) d.mosi         = q.txd[cur_idx];
                        else          d.rxd[cur_idx] = miso;
                    end else begin
                        if (cfg_cpha)                     d.rxd[cur_idx] = miso;
                        else if (bitn != cfg_size_m1)     d.mosi         = q.txd[nxt_idx];
                    end
                    if (q.edg == {cfg_size_m1, 1'b1}) d.st = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (half_end) d.st = ST_FINISH;
            end
            ST_FINISH: begin
                rx_push          = !rx_full;
                d.tcnt           = (q.clr ? '0 : q.tcnt) + HALF_W'(1);
                sets[STAT_DONE]  = 1'b1;
                sets[STAT_EOQ]   = q.eoq;
                sets[STAT_RXOVF] = rx_full;
                sets[STAT_TXUNF] = q.cont && (tx_count < need);
                if (!q.cont) d.cs = '0;
                d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase

        d.status = (q.status & ~(stat_clr_valid ? stat_clr_mask : '0)) | sets;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_word = q.rxd;
    assign sck     = q.sck;
    assign mosi    = q.mosi;
    assign cs_mask = q.cs;
    assign status  = q.status;
    assign tcnt    = q.tcnt;

    // R4: after an even number of toggles the clock is back at its idle level
    assert_sck_idle_after_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_HOLD) |-> (q.sck == cfg_cpol));
    // R5: a non-continuous frame releases its select line
    assert_cs_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_FINISH && !q.cont) |=> (q.cs == '0));
    // R7: the counter steps by one or restarts at one
    assert_tcnt_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_FINISH) |=> (q.tcnt == HALF_W'(1) || q.tcnt == $past(q.tcnt) + HALF_W'(1)));
    // R8: end-of-queue frame raises its flag
    assert_eoq_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_FINISH && q.eoq) |=> q.status[STAT_EOQ]);
endmodule

// File: rtl/spi_cmd_master.sv
module spi_cmd_master
    import spi_cmd_pkg::*;
#(
    parameter int HALF_DIV   = 2,
    parameter int FIFO_DEPTH = 4,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push_valid,
    input  logic [WORD_W-1:0]   push_word,
    output logic                push_ready,
    input  logic                pop_ready,
    output logic                pop_valid,
    output logic [WORD_W-1:0]   pop_data,
    input  logic                cfg_cpol,
    input  logic                cfg_cpha,
    input  logic                cfg_lsb_first,
    input  logic [3:0]          cfg_size,
    input  logic                cfg_size_ext,
    input  logic [CS_LINES-1:0] cfg_cs_idle,
    input  logic                flush_tx,
    input  logic                flush_rx,
    input  logic                stat_clr_valid,
    input  logic [STAT_W-1:0]   stat_clr_mask,
    output logic [STAT_W-1:0]   status,
    output logic [HALF_W-1:0]   xfer_count,
    output logic                sck,
    output logic                mosi,
    input  logic                miso,
    output logic [CS_LINES-1:0] cs_o
);
    logic [WORD_W-1:0]   tx_head, rx_word;
    logic [CNT_W-1:0]    tx_count, rx_count_unused;
    logic                tx_full, tx_empty_unused, tx_pop;
    logic                rx_full, rx_empty, rx_push;
    logic [CS_LINES-1:0] cs_mask;

    assign push_ready = !tx_full;
    assign pop_valid  = !rx_empty;
    assign cs_o       = cfg_cs_idle ^ cs_mask;

    spi_cmd_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(flush_tx),
        .wr_en(push_valid && !tx_full), .wr_data(push_word),
        .rd_en(tx_pop), .rd_data(tx_head),
        .count(tx_count), .full(tx_full), .empty(tx_empty_unused)
    );

    spi_cmd_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(flush_rx),
        .wr_en(rx_push), .wr_data(rx_word),
        .rd_en(pop_ready && !rx_empty), .rd_data(pop_data),
        .count(rx_count_unused), .full(rx_full), .empty(rx_empty)
    );

    spi_cmd_engine #(.HALF_DIV(HALF_DIV), .CNT_W(CNT_W)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first),
        .cfg_size_m1({cfg_size_ext, cfg_size}),
        .tx_head(tx_head), .tx_count(tx_count), .tx_pop(tx_pop),
        .rx_full(rx_full), .rx_push(rx_push), .rx_word(rx_word),
        .miso(miso), .sck(sck), .mosi(mosi), .cs_mask(cs_mask),
        .stat_clr_valid(stat_clr_valid), .stat_clr_mask(stat_clr_mask),
        .status(status), .tcnt(xfer_count)
    );
endmodule

// File: tb/spi_cmd_master_test.sv
module spi_cmd_master_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_valid = 1'b0;
    logic [31:0] push_word = '0;
    logic        push_ready;
    logic        pop_ready = 1'b0;
    logic        pop_valid;
    logic [31:0] pop_data;
    logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0;
    logic [3:0]  cfg_size = 4'd7;
    logic        cfg_size_ext = 1'b0;
    logic [5:0]  cfg_cs_idle = 6'h3F;
    logic        flush_tx = 1'b0, flush_rx = 1'b0;
    logic        stat_clr_valid = 1'b0;
    logic [3:0]  stat_clr_mask = '0;
    logic [3:0]  status;
    logic [15:0] xfer_count;
    logic        sck, mosi, miso;
    logic [5:0]  cs_o;

    int checks = 0, fails = 0, cyc = 0;

    always #5 clk = ~clk;
    assign miso = mosi;

    spi_cmd_master uut (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_word(push_word),
        .push_ready(push_ready), .pop_ready(pop_ready), .pop_valid(pop_valid),
        .pop_data(pop_data), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_lsb_first(cfg_lsb_first), .cfg_size(cfg_size), .cfg_size_ext(cfg_size_ext),
        .cfg_cs_idle(cfg_cs_idle), .flush_tx(flush_tx), .flush_rx(flush_rx),
        .stat_clr_valid(stat_clr_valid), .stat_clr_mask(stat_clr_mask),
        .status(status), .xfer_count(xfer_count), .sck(sck), .mosi(mosi),
        .miso(miso), .cs_o(cs_o)
    );

    task automatic check_eq(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] cmdw(input bit cont, input bit eoq, input bit clr,
                                         input logic [5:0] mask);
        return {cont, 3'b000, eoq, clr, 4'b0000, mask};
    endfunction

    function automatic logic [31:0] expseq(input logic [31:0] data, input int n, input bit lsb);
        logic [31:0] r = '0;
        for (int k = 0; k < n; k++) r[k] = lsb ? data[k] : data[n-1-k];
        return r;
    endfunction

    task automatic push(input logic [31:0] w);
        @(negedge clk);
        while (!push_ready) @(negedge clk);
        push_valid = 1'b1;
        push_word  = w;
        @(negedge clk);
        push_valid = 1'b0;
    endtask

    task automatic pop_expect(input string req, input logic [31:0] exp);
        @(negedge clk);
        check_eq(req, "pop_valid", {31'b0, pop_valid}, 32'd1);
        check_eq(req, "pop_data", pop_data, exp);
        pop_ready = 1'b1;
        @(negedge clk);
        pop_ready = 1'b0;
    endtask

    task automatic clear_stat(input logic [3:0] m);
        @(negedge clk);
        stat_clr_valid = 1'b1;
        stat_clr_mask  = m;
        @(negedge clk);
        stat_clr_valid = 1'b0;
    endtask

    task automatic wait_done();
        int g = 0;
        @(negedge clk);
        while (!status[0] && g < 5000) begin
            @(negedge clk);
            g++;
        end
        check_eq("R8", "frame done flag", {31'b0, status[0]}, 32'd1);
        clear_stat(4'b0001);
    endtask

    task automatic drain();
        @(negedge clk);
        while (pop_valid) begin
            pop_ready = 1'b1;
            @(negedge clk);
        end
        pop_ready = 1'b0;
    endtask

    task automatic capture(input int n, output logic [31:0] seq, output logic [5:0] cs_seen);
        logic prev;
        int   k = 0, g = 0;
        seq = '0;
        cs_seen = '1;
        @(negedge clk);
        prev = sck;
        while (k < n && g < 5000) begin
            @(negedge clk);
            g++;
            if (sck !== prev) begin
                if ((prev == cfg_cpol) != cfg_cpha) begin
                    seq[k] = mosi;
                    if (k == 0) cs_seen = cs_o;
                    k++;
                end
                prev = sck;
            end
        end
    endtask

    task automatic t_reset();
        check_eq("R1", "push_ready after reset", {31'b0, push_ready}, 32'd1);
        check_eq("R6", "pop_valid after reset", {31'b0, pop_valid}, 32'd0);
        check_eq("R8", "status after reset", {28'b0, status}, 32'd0);
        check_eq("R7", "count after reset", {16'b0, xfer_count}, 32'd0);
        check_eq("R5", "cs idle after reset", {26'b0, cs_o}, 32'h3F);
        check_eq("R4", "sck idle after reset", {31'b0, sck}, 32'd0);
    endtask

    task automatic t_basic();
        logic [31:0] seq;
        logic [5:0]  cs_seen;
        fork
            capture(8, seq, cs_seen);
            push({cmdw(0, 0, 0, 6'b000001), 16'hA5C3});
        join
        wait_done();
        check_eq("R3", "msb-first mode0 mosi order", seq, expseq(32'hC3, 8, 0));
        check_eq("R5", "line0 active during frame", {26'b0, cs_seen}, 32'h3E);
        check_eq("R5", "line released after frame", {26'b0, cs_o}, 32'h3F);
        check_eq("R7", "count after first frame", {16'b0, xfer_count}, 32'd1);
        check_eq("R10", "no underflow on plain frame", {31'b0, status[3]}, 32'd0);
        pop_expect("R6", 32'h000000C3);
    endtask

    task automatic t_lsb_mode3();
        logic [31:0] seq;
        logic [5:0]  cs_seen;
        cfg_cpol = 1'b1; cfg_cpha = 1'b1; cfg_lsb_first = 1'b1; cfg_size = 4'd11;
        repeat (3) @(negedge clk);
        check_eq("R4", "sck idles high with cpol", {31'b0, sck}, 32'd1);
        fork
            capture(12, seq, cs_seen);
            push({cmdw(0, 0, 0, 6'b000010), 16'hF935});
        join
        wait_done();
        check_eq("R3", "lsb-first mode3 mosi order", seq, expseq(32'h935, 12, 1));
        check_eq("R4", "sck back high after frame", {31'b0, sck}, 32'd1);
        pop_expect("R6", 32'h00000935);
        cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_lsb_first = 1'b0; cfg_size = 4'd7;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_wide();
        logic [31:0] seq;
        logic [5:0]  cs_seen;
        logic [15:0] c0;
        c0 = xfer_count;
        cfg_size_ext = 1'b1;
        fork
            capture(24, seq, cs_seen);
            begin
                push({cmdw(0, 0, 0, 6'b000010), 16'hBEEF});
                push({cmdw(1, 1, 1, 6'b100000), 16'h1234});
            end
        join
        wait_done();
        check_eq("R2", "24-bit frame mosi order", seq, expseq(32'h34BEEF, 24, 0));
        check_eq("R2", "second command ignored: eoq", {31'b0, status[1]}, 32'd0);
        check_eq("R2", "second command ignored: cs", {26'b0, cs_o}, 32'h3F);
        check_eq("R2", "second command ignored: count", {16'b0, xfer_count}, {16'b0, c0 + 16'd1});
        pop_expect("R2", 32'h0034BEEF);
        cfg_size_ext = 1'b0;
    endtask

    task automatic t_cont_cs();
        cfg_cs_idle = 6'b101011;
        repeat (2) @(negedge clk);
        check_eq("R5", "mixed idle levels", {26'b0, cs_o}, 32'h2B);
        push({cmdw(1, 0, 0, 6'b000100), 16'h005A});
        wait_done();
        check_eq("R5", "continuous keeps line2 active", {26'b0, cs_o}, 32'h2F);
        check_eq("R10", "underflow on starved continuous", {31'b0, status[3]}, 32'd1);
        push({cmdw(0, 0, 0, 6'b000100), 16'h00A5});
        wait_done();
        check_eq("R5", "line2 released", {26'b0, cs_o}, 32'h2B);
        pop_expect("R6", 32'h5A);
        pop_expect("R6", 32'hA5);
        clear_stat(4'b1000);
        check_eq("R8", "w1c clears underflow", {28'b0, status}, 32'd0);
        cfg_cs_idle = 6'h3F;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_counter();
        push({cmdw(0, 0, 1, 6'b000001), 16'h0011});
        wait_done();
        check_eq("R7", "clear-count frame leaves 1", {16'b0, xfer_count}, 32'd1);
        push({cmdw(0, 0, 0, 6'b000001), 16'h0022});
        wait_done();
        check_eq("R7", "next frame counts 2", {16'b0, xfer_count}, 32'd2);
        drain();
    endtask

    task automatic t_eoq();
        push({cmdw(0, 1, 0, 6'b000001), 16'h0033});
        wait_done();
        check_eq("R8", "eoq flag set", {31'b0, status[1]}, 32'd1);
        clear_stat(4'b0010);
        check_eq("R8", "eoq flag cleared by w1c", {28'b0, status}, 32'd0);
        drain();
    endtask

    task automatic t_overflow();
        logic [15:0] c0;
        int g = 0;
        drain();
        c0 = xfer_count;
        for (int i = 1; i <= 5; i++) push({cmdw(0, 0, 0, 6'b000001), 16'(i)});
        while (xfer_count != c0 + 16'd5 && g < 5000) begin
            @(negedge clk);
            g++;
        end
        check_eq("R9", "five frames sent", {16'b0, xfer_count}, {16'b0, c0 + 16'd5});
        check_eq("R9", "overflow flag", {31'b0, status[2]}, 32'd1);
        for (int i = 1; i <= 4; i++) pop_expect("R9", 32'(i));
        @(negedge clk);
        check_eq("R9", "fifth frame dropped", {31'b0, pop_valid}, 32'd0);
        clear_stat(4'hF);
        check_eq("R8", "all flags cleared", {28'b0, status}, 32'd0);
    endtask

    task automatic t_full_flush();
        logic [15:0] c0;
        c0 = xfer_count;
        @(negedge clk);
        push_valid = 1'b1;
        for (int i = 0; i < 5; i++) begin
            push_word = {cmdw(0, 0, 0, 6'b000001), 16'h0040 + 16'(i)};
            @(negedge clk);
        end
        push_valid = 1'b0;
        check_eq("R1", "push_ready low with four queued", {31'b0, push_ready}, 32'd0);
        flush_tx = 1'b1;
        @(negedge clk);
        flush_tx = 1'b0;
        check_eq("R11", "push_ready after tx flush", {31'b0, push_ready}, 32'd1);
        wait_done();
        repeat (200) @(negedge clk);
        check_eq("R11", "flushed frames not sent", {16'b0, xfer_count}, {16'b0, c0 + 16'd1});
        check_eq("R11", "rx holds the one frame", {31'b0, pop_valid}, 32'd1);
        flush_rx = 1'b1;
        @(negedge clk);
        flush_rx = 1'b0;
        check_eq("R11", "rx empty after flush", {31'b0, pop_valid}, 32'd0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc >= 150000) begin
                fails++;
                $display("FAIL watchdog actual=%0d expected=done", cyc);
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_basic();
        t_lsb_mode3();
        t_wide();
        t_cont_cs();
        t_counter();
        t_eoq();
        t_overflow();
        t_full_flush();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule